// File: doc/BRIEF.md
# Flash Status Register and Command Decoder

This block is the status side of a small flash memory controller. Bus write cycles deliver command bytes. The block decodes them, issues start strobes to a write state machine, and collects that machine's completion pulses and result qualifiers into an 8-bit status byte. It also keeps a read-mode flag. The flag steers bus reads either to array data or to the status byte.

Software polls bit 7 until it reads ready, then inspects the error flags. The error flags are sticky. They are set only by operation results or by a malformed erase sequence, and only an explicit clear command drops them. Status read mode stays in force until a command that selects array reads arrives.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x80 (ready, no flags), reads return array data, and neither start strobe is high.
- R2: Command 0x70 selects status read mode, in which rdData equals the status byte. Unknown bytes and command 0x50 leave the mode unchanged.
- R3: Command 0xFF, accepted while ready and not inside an erase setup, selects array read mode, in which rdData equals arrayData.
- R4: Command 0x40 raises progStart for exactly one cycle, drives bit 7 to 0 and selects status read mode. Bit 7 returns to 1 on the cycle after wsmProgDone.
- R5: Command 0x20 followed by 0xD0 raises eraseStart for one cycle and drives bit 7 to 0. Bit 7 returns to 1 on the cycle after wsmEraseDone.
- R6: Any byte other than 0xD0 after 0x20 sets bits 5 and 4 together. No start strobe is raised, and bit 7 stays 1.
- R7: wsmFail sampled with a done pulse sets bit 4 for a program or bit 5 for an erase.
- R8: wsmLockHit sampled with a done pulse sets bit 1 and the flag of the failed operation. wsmLockHit without a done pulse has no effect.
- R9: Bits 5, 4 and 1 are sticky. A later successful operation does not clear them. Only command 0x50, accepted while ready, clears them.
- R10: Status bits 6, 3, 2 and 0 always read 0.
- R11: While busy, every command except 0x70 is ignored, including 0x50, 0xFF and 0x40.
- R12: A done pulse of the wrong kind, or a done pulse while idle, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | One-cycle bus write strobe |
| busWrData | input | DATA_W | Command byte of the write |
| arrayData | input | DATA_W | Data from the memory array |
| wsmProgDone | input | 1 | Program completion pulse |
| wsmEraseDone | input | 1 | Erase completion pulse |
| wsmFail | input | 1 | Operation failed, valid with a done pulse |
| wsmLockHit | input | 1 | Protected sector hit, valid with a done pulse |
| progStart | output | 1 | One-cycle program start strobe |
| eraseStart | output | 1 | One-cycle erase start strobe |
| readStatusMode | output | 1 | 1 when reads return status |
| statusByte | output | 8 | Current status register |
| rdData | output | DATA_W | Read data: status or array |

## Verification
A stimulus table walks command streams that mix mode switches, program and erase runs with clean, failing and lock-abort results, and commands issued while busy. Each step is scored on the status byte, the read mode and the selected read data. The scoring separates a flag that is truly sticky from one that a new operation clears, and it separates ignored busy-time commands from accepted ones. Directed tests cover the reset state, the one-cycle width of the start strobes, a lock input pulsed without a done pulse, and the status bits that always read 0.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_READY = 7;
  localparam int BIT_ERASE = 5;
  localparam int BIT_PROG = 4;
  localparam int BIT_LOCK = 1;

  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE_ARM,
    ST_PROG_BUSY,
    ST_ERASE_BUSY
  } ctlState_t;

  typedef struct packed {
    logic setBusy;
    logic clrBusy;
    logic setProgErr;
    logic setEraseErr;
    logic setLockErr;
    logic clrErr;
  } statStrobe_t;
endpackage

// File: rtl/fsc_control.sv
module fsc_control
  import fsc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              wsmProgDone,
  input  logic              wsmEraseDone,
  input  logic              wsmFail,
  input  logic              wsmLockHit,
  output statStrobe_t       strobe,
  output logic              progStart,
  output logic              eraseStart,
  output logic              readStatusMode
);
  localparam int CMD_W = 8;

  ctlState_t state, stateNext;
  logic modeNext, progNext, eraseNext;
  logic [CMD_W-1:0] cmd;

  assign cmd = busWrData[CMD_W-1:0];

  always_comb begin
    stateNext = state;
    modeNext = readStatusMode;
    progNext = 1'b0;
    eraseNext = 1'b0;
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (busWrEn) begin
          case (cmd)
            CMD_READ_STATUS: modeNext = 1'b1;
            CMD_READ_ARRAY: modeNext = 1'b0;
            CMD_CLEAR_STATUS: strobe.clrErr = 1'b1;
            CMD_PROGRAM: begin
              stateNext = ST_PROG_BUSY;
              strobe.setBusy = 1'b1;
              progNext = 1'b1;
              modeNext = 1'b1;
            end
            CMD_ERASE_SETUP: begin
              stateNext = ST_ERASE_ARM;
              modeNext = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_ERASE_ARM: begin
        if (busWrEn) begin
          if (cmd == CMD_ERASE_CONFIRM) begin
            stateNext = ST_ERASE_BUSY;
            strobe.setBusy = 1'b1;
            eraseNext = 1'b1;
          end else begin
            stateNext = ST_IDLE;
            strobe.setProgErr = 1'b1;
            strobe.setEraseErr = 1'b1;
          end
        end
      end
      ST_PROG_BUSY: begin
        if (busWrEn && cmd == CMD_READ_STATUS) modeNext = 1'b1;
        if (wsmProgDone) begin
          stateNext = ST_IDLE;
          strobe.clrBusy = 1'b1;
          strobe.setProgErr = wsmFail | wsmLockHit;
          strobe.setLockErr = wsmLockHit;
        end
      end
      ST_ERASE_BUSY: begin
        if (busWrEn && cmd == CMD_READ_STATUS) modeNext = 1'b1;
        if (wsmEraseDone) begin
          stateNext = ST_IDLE;
          strobe.clrBusy = 1'b1;
          strobe.setEraseErr = wsmFail | wsmLockHit;
          strobe.setLockErr = wsmLockHit;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      readStatusMode <= 1'b0;
      progStart <= 1'b0;
      eraseStart <= 1'b0;
    end else begin
      state <= stateNext;
      readStatusMode <= modeNext;
      progStart <= progNext;
      eraseStart <= eraseNext;
    end
  end

  AST_STARTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, eraseStart})); // R5
  AST_PROG_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart); // R4
  AST_PROG_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG_BUSY && !wsmProgDone) |=> state == ST_PROG_BUSY); // R4
  AST_ERASE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE_BUSY && !wsmEraseDone) |=> state == ST_ERASE_BUSY); // R5
  AST_BUSY_IGNORES_ARRAY: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_PROG_BUSY, ST_ERASE_BUSY} && busWrEn) |=> readStatusMode); // R11
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  output logic [STAT_W-1:0] statusByte
);
  logic readyQ, progErrQ, eraseErrQ, lockErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b1;
      progErrQ <= 1'b0;
      eraseErrQ <= 1'b0;
      lockErrQ <= 1'b0;
    end else begin
      if (strobe.setBusy) readyQ <= 1'b0;
      else if (strobe.clrBusy) readyQ <= 1'b1;
      if (strobe.clrErr) begin
        progErrQ <= 1'b0;
        eraseErrQ <= 1'b0;
        lockErrQ <= 1'b0;
      end else begin
        if (strobe.setProgErr) progErrQ <= 1'b1;
        if (strobe.setEraseErr) eraseErrQ <= 1'b1;
        if (strobe.setLockErr) lockErrQ <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_statBit
    if (b == BIT_READY) begin : g_ready
      assign statusByte[b] = readyQ;
    end else if (b == BIT_ERASE) begin : g_erase
      assign statusByte[b] = eraseErrQ;
    end else if (b == BIT_PROG) begin : g_prog
      assign statusByte[b] = progErrQ;
    end else if (b == BIT_LOCK) begin : g_lock
      assign statusByte[b] = lockErrQ;
    end else begin : g_reserved
      assign statusByte[b] = 1'b0;
    end
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte & 8'b0100_1101) == 8'h00); // R10
  AST_PROG_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progErrQ) |-> $past(strobe.clrErr)); // R9
  AST_ERASE_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eraseErrQ) |-> $past(strobe.clrErr)); // R9
  AST_LOCK_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockErrQ) |-> $past(strobe.clrErr)); // R9
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyQ) |-> $past(strobe.setBusy)); // R4
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              wsmProgDone,
  input  logic              wsmEraseDone,
  input  logic              wsmFail,
  input  logic              wsmLockHit,
  output logic              progStart,
  output logic              eraseStart,
  output logic              readStatusMode,
  output logic [7:0]        statusByte,
  output logic [DATA_W-1:0] rdData
);
  statStrobe_t strobe;

  fsc_control #(.DATA_W(DATA_W)) i_control (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .wsmProgDone(wsmProgDone), .wsmEraseDone(wsmEraseDone),
    .wsmFail(wsmFail), .wsmLockHit(wsmLockHit), .strobe(strobe),
    .progStart(progStart), .eraseStart(eraseStart),
    .readStatusMode(readStatusMode)
  );

  fsc_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusByte(statusByte)
  );

  assign rdData = readStatusMode ? DATA_W'(statusByte) : arrayData;

  AST_STATUS_MODE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWrData[7:0] == CMD_READ_STATUS) |=> readStatusMode); // R2
  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && !wsmProgDone && !wsmEraseDone) |=> $stable(statusByte)); // R8
endmodule

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;
  localparam int N_VEC = 24;
  localparam logic [7:0] ARR = 8'h5A;
  // entry: {op, flags{fail,lock,2'b0}, data, expected status, 7'b0, expected mode}
  // op: 0 command write, 1 program done pulse, 2 erase done pulse
  localparam logic [31:0] VEC [N_VEC] = '{
    {4'd0, 4'h0, 8'h70, 8'h80, 8'h01},
    {4'd0, 4'h0, 8'hFF, 8'h80, 8'h00},
    {4'd0, 4'h0, 8'h40, 8'h00, 8'h01},
    {4'd0, 4'h0, 8'h50, 8'h00, 8'h01},
    {4'd0, 4'h0, 8'hFF, 8'h00, 8'h01},
    {4'd1, 4'h8, 8'h00, 8'h90, 8'h01},
    {4'd0, 4'h0, 8'h40, 8'h10, 8'h01},
    {4'd1, 4'h0, 8'h00, 8'h90, 8'h01},
    {4'd0, 4'h0, 8'h50, 8'h80, 8'h01},
    {4'd0, 4'h0, 8'h20, 8'h80, 8'h01},
    {4'd0, 4'h0, 8'hD0, 8'h00, 8'h01},
    {4'd1, 4'h0, 8'h00, 8'h00, 8'h01},
    {4'd2, 4'h4, 8'h00, 8'hA2, 8'h01},
    {4'd0, 4'h0, 8'h50, 8'h80, 8'h01},
    {4'd0, 4'h0, 8'h20, 8'h80, 8'h01},
    {4'd0, 4'h0, 8'h33, 8'hB0, 8'h01},
    {4'd0, 4'h0, 8'hFF, 8'hB0, 8'h00},
    {4'd2, 4'h0, 8'h00, 8'hB0, 8'h00},
    {4'd0, 4'h0, 8'h13, 8'hB0, 8'h00},
    {4'd0, 4'h0, 8'h50, 8'h80, 8'h00},
    {4'd0, 4'h0, 8'h20, 8'h80, 8'h01},
    {4'd0, 4'h0, 8'hD0, 8'h00, 8'h01},
    {4'd0, 4'h0, 8'h70, 8'h00, 8'h01},
    {4'd2, 4'h8, 8'h00, 8'hA0, 8'h01}
  };
  localparam string TAG [N_VEC] = '{
    "R2", "R3", "R4", "R11", "R11", "R7", "R4", "R9", "R9", "R6",
    "R5", "R12", "R8", "R9", "R6", "R6", "R3", "R12", "R2", "R9",
    "R5", "R5", "R11", "R7"
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] arrayData = ARR;
  logic wsmProgDone = 1'b0, wsmEraseDone = 1'b0, wsmFail = 1'b0, wsmLockHit = 1'b0;
  logic progStart, eraseStart, readStatusMode;
  logic [7:0] statusByte, rdData;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  flash_status_ctrl i_flash_status_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .arrayData(arrayData), .wsmProgDone(wsmProgDone), .wsmEraseDone(wsmEraseDone),
    .wsmFail(wsmFail), .wsmLockHit(wsmLockHit), .progStart(progStart),
    .eraseStart(eraseStart), .readStatusMode(readStatusMode),
    .statusByte(statusByte), .rdData(rdData)
  );

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [3:0] flg, input logic [7:0] d);
    @(negedge clk);
    busWrEn = (op == 4'd0);
    busWrData = d;
    wsmProgDone = (op == 4'd1);
    wsmEraseDone = (op == 4'd2);
    wsmFail = flg[3];
    wsmLockHit = flg[2];
    @(negedge clk);
    busWrEn = 1'b0;
    wsmProgDone = 1'b0;
    wsmEraseDone = 1'b0;
    wsmFail = 1'b0;
    wsmLockHit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "status", statusByte, 8'h80);
    check("R1", "mode", {7'b0, readStatusMode}, 8'h00);
    check("R1", "rdData", rdData, ARR);
    check("R1", "starts", {6'b0, progStart, eraseStart}, 8'h00);

    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][31:28], VEC[i][27:24], VEC[i][23:16]);
      check(TAG[i], $sformatf("step %0d status", i), statusByte, VEC[i][15:8]);
      check(TAG[i], $sformatf("step %0d mode", i), {7'b0, readStatusMode}, VEC[i][7:0]);
      check(TAG[i], $sformatf("step %0d rdData", i), rdData,
            VEC[i][0] ? VEC[i][15:8] : ARR);
      // R10 reserved bits always zero
      check("R10", $sformatf("step %0d reserved", i), statusByte & 8'h4D, 8'h00);
    end

    // R4 program start strobe lasts one cycle
    step(4'd0, 4'h0, 8'h40);
    check("R4", "progStart high", {7'b0, progStart}, 8'h01);
    check("R4", "eraseStart low", {7'b0, eraseStart}, 8'h00);
    @(negedge clk);
    check("R4", "progStart one cycle", {7'b0, progStart}, 8'h00);
    check("R4", "still busy", statusByte, 8'h20);
    // R12 erase done during program is ignored
    step(4'd2, 4'h8, 8'h00);
    check("R12", "wrong done kind", statusByte, 8'h20);
    step(4'd1, 4'h0, 8'h00);
    check("R4", "ready after done", statusByte, 8'hA0);

    // R5 erase start strobe lasts one cycle
    step(4'd0, 4'h0, 8'h20);
    check("R5", "no start on setup", {6'b0, progStart, eraseStart}, 8'h00);
    step(4'd0, 4'h0, 8'hD0);
    check("R5", "eraseStart high", {7'b0, eraseStart}, 8'h01);
    @(negedge clk);
    check("R5", "eraseStart one cycle", {7'b0, eraseStart}, 8'h00);
    step(4'd2, 4'h0, 8'h00);
    check("R5", "ready after erase done", statusByte, 8'hA0);

    // R8 lock input without a done pulse has no effect
    step(4'd0, 4'h0, 8'h50);
    @(negedge clk);
    wsmLockHit = 1'b1;
    wsmFail = 1'b1;
    @(negedge clk);
    wsmLockHit = 1'b0;
    wsmFail = 1'b0;
    @(negedge clk);
    check("R8", "lock ignored when idle", statusByte, 8'h80);

    // R6 bad confirm raises no start strobe
    step(4'd0, 4'h0, 8'h20);
    step(4'd0, 4'h0, 8'hFF);
    check("R6", "no start on bad confirm", {6'b0, progStart, eraseStart}, 8'h00);
    check("R6", "both flags", statusByte, 8'hB0);

    // R8 program with lock abort sets lock and program flags
    step(4'd0, 4'h0, 8'h50);
    step(4'd0, 4'h0, 8'h40);
    step(4'd1, 4'h4, 8'h00);
    check("R8", "program lock abort", statusByte, 8'h92);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule